// File: doc/BRIEF.md
# Block-transfer host register port

This block is the host-facing half of a byte-wide mailbox that moves request and response messages between a host and a management controller. The host sees three byte registers, selected by the two low address bits: a control register, a data port and an interrupt mask register. Host writes to the data port build an inbound request byte by byte. Host reads of the data port drain an outbound response. A write to the control register can do several things at once. It can rewind either buffer pointer, acknowledge attention flags and flip the host-busy flag. It can also hand the finished request over to the controller side.

The controller side reads the inbound request through an indexed peek port, together with its length. A single-cycle request strobe tells it that a request is ready. It returns the response as a valid/ready byte stream. `rsp_ready` is high only while no response is waiting to be read by the host. A byte moves on every cycle where `rsp_valid` and `rsp_ready` are both high. The byte marked `rsp_last` closes the response and makes it readable. The stream then stalls until the host has read every byte of it. The controller must hold `rsp_data` and `rsp_last` steady while it waits for ready.

The mask register is only stored and exported here. Interrupt generation and message interpretation are done elsewhere.

Top module: `bt_host_port`

## Requirements
- R1: `host_addr` selects the register: 0 is control, 1 is data, 2 is mask. A read of offset 3 returns 0xFF, and a write to offset 3 changes no state.
- R2: Each data-port write stores the byte at inbound index `req_len` when `req_len` is below DEPTH (default 64), and then increments `req_len`. `req_len` keeps counting past DEPTH so that an overrun stays visible, and it saturates at 255. Bytes written past DEPTH are dropped.
- R3: A control write with bit 0 set returns `req_len` to zero.
- R4: A control write with bit 1 set rewinds the outbound read position to the first byte and leaves the response length unchanged, so the response can be read again.
- R5: A control write with bit 3 set clears the controller-to-host attention flag, and bit 4 set clears the controller-message attention flag. A 0 in either bit leaves that flag unchanged.
- R6: A control write with bit 6 set inverts the host-busy flag.
- R7: A control write with bit 2 set sets the controller-busy flag and raises `req_strobe` for exactly one cycle, the cycle after the write.
- R8: A control read returns controller-busy in bit 7, host-busy in bit 6, controller-message attention in bit 4 and controller-to-host attention in bit 3. All other bits read 0. After reset the control register reads 0x00.
- R9: When the `rsp_last` byte is accepted, the response becomes readable with a length of min(bytes sent, DEPTH). In the same step controller-busy clears, controller-to-host attention sets and `rsp_ready` falls. After reset `rsp_ready` is high.
- R10: A data-port read returns the next outbound byte and advances the position. After the last byte the response is gone: later reads return 0xFF and `rsp_ready` rises again.
- R11: A data-port read with no response pending returns 0xFF.
- R12: `host_rdata` is registered and valid the cycle after `host_rd` rises. It is held until the next read. A read held high for several cycles has its side effect only once.
- R13: A write to the mask register stores the byte. It reads back at offset 2 and drives `irq_mask`. Reset value is 0x00.
- R14: A pulse on `sms_set` sets the controller-message attention flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write; one write per cycle it is high |
| host_rd | input | 1 | Host read; side effect taken on its rising cycle |
| host_addr | input | 2 | Register offset |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Registered host read byte |
| req_strobe | output | 1 | One-cycle request hand-over pulse |
| req_len | output | 8 | Inbound byte count (saturating) |
| req_idx | input | 6 | Inbound peek index |
| req_byte | output | 8 | Inbound byte at `req_idx` |
| rsp_valid | input | 1 | Response byte valid |
| rsp_data | input | 8 | Response byte |
| rsp_last | input | 1 | Marks the final response byte |
| rsp_ready | output | 1 | Response stream can accept a byte |
| sms_set | input | 1 | Sets controller-message attention |
| irq_mask | output | 8 | Stored mask register |

## Verification
The data-port path is driven with short messages, with a request that overruns the buffer well past its depth, and with a response longer than the buffer. These patterns separate correct indexing from wrap-around and separate saturation from overflow. The control register is exercised with single-bit writes and with zero-bit writes. This shows that each write-1 action touches only its own flag, and that the toggle is distinguished from a set. Responses are read in order, rewound part way through, read past their end, and read with a held read line. These cases separate correct pointer advance from double advance, stale data and failure to free the buffer.

// File: rtl/bt_host_pkg.sv
package bt_host_pkg;

  localparam logic [1:0] OFS_CTRL = 2'd0;
  localparam logic [1:0] OFS_DATA = 2'd1;
  localparam logic [1:0] OFS_MASK = 2'd2;

  localparam int B_CLR_IN    = 0;
  localparam int B_CLR_OUT   = 1;
  localparam int B_DOORBELL  = 2;
  localparam int B_C2H_ATN   = 3;
  localparam int B_MSG_ATN   = 4;
  localparam int B_HOST_BUSY = 6;
  localparam int B_CTRL_BUSY = 7;

  localparam logic [7:0] IDLE_BYTE = 8'hFF;

  typedef struct packed {
    logic ctrl_busy;
    logic host_busy;
    logic msg_atn;
    logic c2h_atn;
  } flags_t;

  function automatic logic [7:0] pack_ctrl(input flags_t f);
    logic [7:0] b;
    b = '0;
    b[B_CTRL_BUSY] = f.ctrl_busy;
    b[B_HOST_BUSY] = f.host_busy;
    b[B_MSG_ATN]   = f.msg_atn;
    b[B_C2H_ATN]   = f.c2h_atn;
    return b;
  endfunction

endpackage

// File: rtl/bt_ctrl_reg.sv
module bt_ctrl_reg
  import bt_host_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_wr,
  input  logic [7:0] wdata,
  input  logic       rsp_done,
  input  logic       msg_set,
  output flags_t     flags,
  output logic       req_strobe
);

  logic ring;
  assign ring = ctrl_wr & wdata[B_DOORBELL];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags      <= '0;
      req_strobe <= 1'b0;
    end else begin
      req_strobe <= ring;

      if (ctrl_wr && wdata[B_HOST_BUSY])
        flags.host_busy <= ~flags.host_busy;

      // a fresh event wins over an acknowledge in the same cycle
      if (rsp_done)
        flags.c2h_atn <= 1'b1;
      else if (ctrl_wr && wdata[B_C2H_ATN])
        flags.c2h_atn <= 1'b0;

      if (msg_set)
        flags.msg_atn <= 1'b1;
      else if (ctrl_wr && wdata[B_MSG_ATN])
        flags.msg_atn <= 1'b0;

      if (ring)
        flags.ctrl_busy <= 1'b1;
      else if (rsp_done)
        flags.ctrl_busy <= 1'b0;
    end
  end

endmodule

// File: rtl/bt_inbound_buf.sv
module bt_inbound_buf #(
  parameter int DEPTH = 64,
  parameter int LEN_W = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [7:0]       push_byte,
  input  logic             clear,
  input  logic [IDX_W-1:0] peek_idx,
  output logic [LEN_W-1:0] len,
  output logic [7:0]       peek_byte
);

  localparam logic [LEN_W-1:0] LEN_MAX  = '1;
  localparam logic [LEN_W-1:0] LEN_DEEP = LEN_W'(DEPTH);

  logic [7:0] mem [DEPTH];
  logic       room;

  assign room = (len < LEN_DEEP);

  always_ff @(posedge clk) begin
    if (push && room)
      mem[len[IDX_W-1:0]] <= push_byte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      len <= '0;
    else if (clear)
      len <= '0;
    else if (push && (len != LEN_MAX))
      len <= len + 1'b1;
  end

  always_comb begin
    if ({1'b0, peek_idx} < (IDX_W + 1)'(DEPTH))
      peek_byte = mem[peek_idx];
    else
      peek_byte = 8'h00;
  end

endmodule

// File: rtl/bt_outbound_buf.sv
module bt_outbound_buf #(
  parameter int DEPTH = 64,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rsp_valid,
  input  logic [7:0] rsp_data,
  input  logic       rsp_last,
  output logic       rsp_ready,
  output logic       load_done,
  input  logic       pop,
  input  logic       rewind,
  output logic       pending,
  output logic [7:0] head_byte
);

  localparam logic [CNT_W-1:0] CNT_DEEP = CNT_W'(DEPTH);

  logic [7:0]       mem [DEPTH];
  logic [CNT_W-1:0] out_len;
  logic [CNT_W-1:0] out_pos;
  logic [CNT_W-1:0] fill_cnt;
  logic [CNT_W-1:0] fill_next;
  logic             accept;

  assign rsp_ready = (out_len == '0);
  assign pending   = (out_len != '0);
  assign accept    = rsp_valid & rsp_ready;
  assign load_done = accept & rsp_last;
  assign fill_next = (fill_cnt == CNT_DEEP) ? fill_cnt : fill_cnt + 1'b1;
  assign head_byte = mem[out_pos[IDX_W-1:0]];

  always_ff @(posedge clk) begin
    if (accept && (fill_cnt < CNT_DEEP))
      mem[fill_cnt[IDX_W-1:0]] <= rsp_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_len  <= '0;
      out_pos  <= '0;
      fill_cnt <= '0;
    end else begin
      if (accept) begin
        if (rsp_last) begin
          out_len  <= fill_next;
          out_pos  <= '0;
          fill_cnt <= '0;
        end else begin
          fill_cnt <= fill_next;
        end
      end else if (rewind) begin
        out_pos <= '0;
      end else if (pop && pending) begin
        if (CNT_W'(out_pos + 1'b1) == out_len) begin
          out_pos <= '0;
          out_len <= '0;
        end else begin
          out_pos <= out_pos + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/bt_host_port.sv
module bt_host_port
  import bt_host_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int FIT_W = $clog2(DEPTH + 1),
  localparam int LEN_W = (FIT_W > 8) ? FIT_W : 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_wr,
  input  logic             host_rd,
  input  logic [1:0]       host_addr,
  input  logic [7:0]       host_wdata,
  output logic [7:0]       host_rdata,
  output logic             req_strobe,
  output logic [LEN_W-1:0] req_len,
  input  logic [IDX_W-1:0] req_idx,
  output logic [7:0]       req_byte,
  input  logic             rsp_valid,
  input  logic [7:0]       rsp_data,
  input  logic             rsp_last,
  output logic             rsp_ready,
  input  logic             sms_set,
  output logic [7:0]       irq_mask
);

  logic       wr_ctrl, wr_data, wr_mask;
  logic       rd_hold_q, rd_pulse, rd_data;
  logic       rsp_done, rsp_pending;
  logic [7:0] head_byte, ctrl_byte, rd_mux, mask_q;
  flags_t     flags;

  assign wr_ctrl  = host_wr && (host_addr == OFS_CTRL);
  assign wr_data  = host_wr && (host_addr == OFS_DATA);
  assign wr_mask  = host_wr && (host_addr == OFS_MASK);
  assign rd_pulse = host_rd & ~rd_hold_q;
  assign rd_data  = rd_pulse && (host_addr == OFS_DATA);

  bt_ctrl_reg u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_wr    (wr_ctrl),
    .wdata      (host_wdata),
    .rsp_done   (rsp_done),
    .msg_set    (sms_set),
    .flags      (flags),
    .req_strobe (req_strobe)
  );

  bt_inbound_buf #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_in (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (wr_data),
    .push_byte (host_wdata),
    .clear     (wr_ctrl && host_wdata[B_CLR_IN]),
    .peek_idx  (req_idx),
    .len       (req_len),
    .peek_byte (req_byte)
  );

  bt_outbound_buf #(.DEPTH(DEPTH)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .rsp_last  (rsp_last),
    .rsp_ready (rsp_ready),
    .load_done (rsp_done),
    .pop       (rd_data),
    .rewind    (wr_ctrl && host_wdata[B_CLR_OUT]),
    .pending   (rsp_pending),
    .head_byte (head_byte)
  );

  assign ctrl_byte = pack_ctrl(flags);
  assign irq_mask  = mask_q;

  always_comb begin
    unique case (host_addr)
      OFS_CTRL: rd_mux = ctrl_byte;
      OFS_DATA: rd_mux = rsp_pending ? head_byte : IDLE_BYTE;
      OFS_MASK: rd_mux = mask_q;
      default:  rd_mux = IDLE_BYTE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_hold_q  <= 1'b0;
      host_rdata <= '0;
      mask_q     <= '0;
    end else begin
      rd_hold_q <= host_rd;
      if (rd_pulse)
        host_rdata <= rd_mux;
      if (wr_mask)
        mask_q <= host_wdata;
    end
  end

endmodule

// File: rtl/bt_host_port_chk.sv
module bt_host_port_chk #(
  parameter int LEN_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             host_wr,
  input logic [1:0]       host_addr,
  input logic [7:0]       host_wdata,
  input logic [7:0]       host_rdata,
  input logic             req_strobe,
  input logic [LEN_W-1:0] req_len,
  input logic             rsp_valid,
  input logic             rsp_last,
  input logic             rsp_ready,
  input logic             rd_pulse,
  input logic             rsp_pending,
  input logic [7:0]       ctrl_byte
);

  localparam logic [LEN_W-1:0] LEN_MAX = '1;

  p_len_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == 2'd1 && req_len != LEN_MAX) |=>
      req_len == $past(req_len) + 1'b1);

  p_len_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == 2'd0 && host_wdata[0]) |=> req_len == '0);

  p_busy_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == 2'd0 && host_wdata[6]) |=>
      ctrl_byte[6] != $past(ctrl_byte[6]));

  p_doorbell_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == 2'd0 && host_wdata[2]) |=> req_strobe && ctrl_byte[7]);

  p_strobe_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_strobe |-> $past(host_wr && host_addr == 2'd0 && host_wdata[2]));

  p_load_close_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready && rsp_last) |=> !rsp_ready && ctrl_byte[3]);

  p_empty_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pulse && host_addr == 2'd1 && !rsp_pending) |=> host_rdata == 8'hFF);

  p_gap_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pulse && host_addr == 2'd3) |=> host_rdata == 8'hFF);

  p_rdata_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_pulse |=> $stable(host_rdata));

endmodule

bind bt_host_port bt_host_port_chk #(.LEN_W(LEN_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .host_wr     (host_wr),
  .host_addr   (host_addr),
  .host_wdata  (host_wdata),
  .host_rdata  (host_rdata),
  .req_strobe  (req_strobe),
  .req_len     (req_len),
  .rsp_valid   (rsp_valid),
  .rsp_last    (rsp_last),
  .rsp_ready   (rsp_ready),
  .rd_pulse    (rd_pulse),
  .rsp_pending (rsp_pending),
  .ctrl_byte   (ctrl_byte)
);

// File: tb/bt_host_port_tb.sv
module bt_host_port_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr = 1'b0, host_rd = 1'b0;
  logic [1:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       req_strobe;
  logic [7:0] req_len;
  logic [5:0] req_idx = '0;
  logic [7:0] req_byte;
  logic       rsp_valid = 1'b0, rsp_last = 1'b0;
  logic [7:0] rsp_data = '0;
  logic       rsp_ready;
  logic       sms_set = 1'b0;
  logic [7:0] irq_mask;

  int  n_checks = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  always #2 clk = ~clk;

  bt_host_port u_dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .req_strobe(req_strobe), .req_len(req_len), .req_idx(req_idx),
    .req_byte(req_byte), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_last(rsp_last), .rsp_ready(rsp_ready), .sms_set(sms_set),
    .irq_mask(irq_mask)
  );

  // vector: op[27:26] addr[25:24] data[23:16] expect[15:8] req[7:0]
  // op 0 = host write, 1 = host read, 2 = compare req_len, 3 = compare req_byte at index data
  localparam int NV = 25;
  localparam logic [27:0] VEC [NV] = '{
    {2'd1, 2'd0, 8'h00, 8'h00, 8'd8},   // R8 control after reset
    {2'd1, 2'd2, 8'h00, 8'h00, 8'd13},  // R13 mask after reset
    {2'd1, 2'd1, 8'h00, 8'hFF, 8'd11},  // R11 empty data read
    {2'd1, 2'd3, 8'h00, 8'hFF, 8'd1},   // R1 offset 3 read
    {2'd0, 2'd1, 8'hA1, 8'h00, 8'd2},   // R2
    {2'd0, 2'd1, 8'hB2, 8'h00, 8'd2},
    {2'd0, 2'd1, 8'hC3, 8'h00, 8'd2},
    {2'd2, 2'd0, 8'h00, 8'h03, 8'd2},   // R2 length
    {2'd3, 2'd0, 8'h01, 8'hB2, 8'd2},   // R2 contents
    {2'd3, 2'd0, 8'h02, 8'hC3, 8'd2},
    {2'd0, 2'd2, 8'h5A, 8'h00, 8'd13},  // R13
    {2'd1, 2'd2, 8'h00, 8'h5A, 8'd13},
    {2'd0, 2'd3, 8'h77, 8'h00, 8'd1},   // R1 write to offset 3
    {2'd1, 2'd0, 8'h00, 8'h00, 8'd1},
    {2'd1, 2'd2, 8'h00, 8'h5A, 8'd1},
    {2'd2, 2'd0, 8'h00, 8'h03, 8'd1},
    {2'd0, 2'd0, 8'h40, 8'h00, 8'd6},   // R6 toggle on
    {2'd1, 2'd0, 8'h00, 8'h40, 8'd6},
    {2'd0, 2'd0, 8'h40, 8'h00, 8'd6},   // R6 toggle off
    {2'd1, 2'd0, 8'h00, 8'h00, 8'd6},
    {2'd0, 2'd0, 8'h01, 8'h00, 8'd3},   // R3 clear inbound
    {2'd2, 2'd0, 8'h00, 8'h00, 8'd3},
    {2'd0, 2'd0, 8'h04, 8'h00, 8'd7},   // R7 doorbell
    {2'd1, 2'd0, 8'h00, 8'h80, 8'd7},
    {2'd1, 2'd3, 8'h00, 8'hFF, 8'd1}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic host_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    host_rd = 1'b1; host_addr = a;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic send_rsp(input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rsp_valid = 1'b1; rsp_data = base + 8'(i); rsp_last = (i == n - 1);
    end
    @(negedge clk);
    rsp_valid = 1'b0; rsp_last = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 ready after reset", {7'd0, rsp_ready}, 8'h01);
    check("R7 strobe low after reset", {7'd0, req_strobe}, 8'h00);

    for (int k = 0; k < NV; k++) begin
      logic [27:0] e;
      string tag;
      e = VEC[k];
      tag = $sformatf("R%0d vec%0d", e[7:0], k);
      case (e[27:26])
        2'd0: host_write(e[25:24], e[23:16]);
        2'd1: begin host_read(e[25:24], v); check(tag, v, e[15:8]); end
        2'd2: begin @(negedge clk); check(tag, req_len, e[15:8]); end
        default: begin
          @(negedge clk); req_idx = e[21:16]; #1;
          check(tag, req_byte, e[15:8]);
        end
      endcase
    end

    // R7 strobe timing: high the cycle after the write, then low
    host_write(2'd0, 8'h04);
    check("R7 strobe high", {7'd0, req_strobe}, 8'h01);
    @(negedge clk);
    check("R7 strobe one cycle", {7'd0, req_strobe}, 8'h00);

    // R9 response hand-back
    send_rsp(3, 8'h11);
    check("R9 ready low while pending", {7'd0, rsp_ready}, 8'h00);
    host_read(2'd0, v); check("R9 busy clear attention set", v, 8'h08);
    host_read(2'd1, v); check("R10 byte0", v, 8'h11);
    host_read(2'd1, v); check("R10 byte1", v, 8'h12);
    host_write(2'd0, 8'h02);
    host_read(2'd1, v); check("R4 rewind", v, 8'h11);
    host_read(2'd1, v); check("R10 after rewind", v, 8'h12);
    host_read(2'd1, v); check("R10 last", v, 8'h13);
    host_read(2'd1, v); check("R10 drained", v, 8'hFF);
    check("R10 ready after drain", {7'd0, rsp_ready}, 8'h01);

    // R5 / R14 attention flags
    host_write(2'd0, 8'h08);
    host_read(2'd0, v); check("R5 clear c2h", v, 8'h00);
    @(negedge clk); sms_set = 1'b1; @(negedge clk); sms_set = 1'b0;
    host_read(2'd0, v); check("R14 msg attention", v, 8'h10);
    host_write(2'd0, 8'h08);
    host_read(2'd0, v); check("R5 zero bit no effect", v, 8'h10);
    host_write(2'd0, 8'h10);
    host_read(2'd0, v); check("R5 clear msg", v, 8'h00);

    // R12 held read advances once
    send_rsp(2, 8'hAA);
    @(negedge clk); host_rd = 1'b1; host_addr = 2'd1;
    repeat (3) @(negedge clk);
    check("R12 held value", host_rdata, 8'hAA);
    host_rd = 1'b0;
    host_read(2'd1, v); check("R12 single advance", v, 8'hAB);
    host_read(2'd1, v); check("R11 empty after", v, 8'hFF);

    // R2 overrun and saturation
    host_write(2'd0, 8'h01);
    for (int i = 0; i < 70; i++) host_write(2'd1, 8'(i));
    @(negedge clk); check("R2 overrun length", req_len, 8'd70);
    req_idx = 6'd63; #1; check("R2 last slot", req_byte, 8'd63);
    for (int i = 0; i < 200; i++) host_write(2'd1, 8'hEE);
    @(negedge clk); check("R2 saturation", req_len, 8'd255);
    req_idx = 6'd63; #1; check("R2 no overwrite", req_byte, 8'd63);

    // R9 response longer than the buffer
    send_rsp(70, 8'h00);
    begin
      int bad = 0;
      for (int i = 0; i < 64; i++) begin
        host_read(2'd1, v);
        if (v !== 8'(i)) bad++;
      end
      check("R9 truncated content errors", 8'(bad), 8'h00);
    end
    host_read(2'd1, v); check("R9 truncated length", v, 8'hFF);
    check("R13 exported mask", irq_mask, 8'h5A);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule